// File: doc/BRIEF.md
# Timer Register Bus Front End with Interrupt Flags

This block sits between an 8-bit register bus and a 16-bit timer core. Each of the core's four 16-bit registers (count, compare A, compare B, capture) appears on the bus as two byte addresses. Those registers are read and written through one shared holding byte. This makes every 16-bit transfer atomic, even though the bus only moves 8 bits at a time. The block does not store those registers. It reads their live values from the core. It hands the core a 16-bit value together with a one-cycle load strobe for the register being written.

The block also owns an interrupt enable register and an interrupt status register. Four event pulses from the core can raise a status bit: overflow, compare A, compare B and capture. Software clears a status bit by writing a one to it. The interrupt controller clears it by acknowledging that source. A request line per source and one combined request line go to the interrupt controller.

Top module: `tmr_bus_if`

## Requirements
- R1: A write to a high-byte address (odd address 1, 3, 5 or 7) only stores the byte in the shared holding latch; no load strobe pulses in the next cycle.
- R2: A write to a low-byte address (even address 0, 2, 4 or 6) raises exactly one load strobe in the next cycle, bit address/2 (0 count, 1 compare A, 2 compare B, 3 capture). The value presented is {holding latch, written byte}.
- R3: A read of a low-byte address returns the low byte of that register in the next cycle and copies its high byte into the holding latch. A later read of any high-byte address returns the latch, even if the core value has changed in between.
- R4: All four registers share one holding latch, so a high-byte write to one register followed by a low-byte write to another commits the latched byte into the second register.
- R5: Reading the status register (address 9) returns capture on bit 5, compare B on bit 2, compare A on bit 1 and overflow on bit 0, with all other bits 0.
- R6: The enable register (address 8) uses the same bit positions, keeps only those four bits, and reads back 0 on every other bit; addresses 10 to 15 read 0.
- R7: An event pulse sets its status bit at the next clock edge.
- R8: Writing the status register clears each status bit whose written bit is 1; bits written 0 keep their value.
- R9: Acknowledge bit k (0 overflow, 1 compare A, 2 compare B, 3 capture) clears that status bit at the next edge.
- R10: When an event and a clear (by write or by acknowledge) hit the same status bit in the same cycle, the bit ends up set.
- R11: Request k is high exactly when status bit k and enable bit k are both 1; the combined request is the OR of the four.
- R12: After reset the holding latch, both registers, the read data and all strobes and requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata the next cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read byte, held until the next read |
| wide_rd | input | 64 | Live core values: count [15:0], compare A [31:16], compare B [47:32], capture [63:48] |
| wide_wval | output | 16 | 16-bit value to load into the core |
| wide_load | output | 4 | One-hot load strobe per 16-bit register |
| ev_ovf | input | 1 | Overflow event pulse |
| ev_cmpa | input | 1 | Compare A event pulse |
| ev_cmpb | input | 1 | Compare B event pulse |
| ev_cap | input | 1 | Capture event pulse |
| irq_ack | input | 4 | Per-source interrupt acknowledge |
| irq_req | output | 4 | Per-source interrupt request |
| irq_any | output | 1 | OR of all requests |

## Verification
An event pulse can land on the same edge as a software clear of the same status bit. It can also land on the same edge as an acknowledge of that source. Both updates then target one flip-flop. The bench drives each event together with a one-bit status write, and separately together with the matching acknowledge. It then reads the register back and checks that the bit stayed set and that its request line is still raised. A random phase mixes events, acknowledges and status writes freely, and a cycle-level model judges every edge.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int N_WIDE = 4;
  localparam int N_SRC  = 4;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] WIDE_SPAN = ADDR_W'(2 * N_WIDE);
  localparam logic [ADDR_W-1:0] ADR_ENA   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] ADR_STAT  = ADDR_W'(9);

  // source index -> bit position in the enable/status byte
  function automatic int src_bit(input int s);
    case (s)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 5;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] pack_src(input logic [N_SRC-1:0] v);
    logic [BYTE_W-1:0] b;
    b = '0;
    for (int i = 0; i < N_SRC; i++) b[src_bit(i)] = v[i];
    return b;
  endfunction

  function automatic logic [N_SRC-1:0] unpack_src(input logic [BYTE_W-1:0] b);
    logic [N_SRC-1:0] v;
    for (int i = 0; i < N_SRC; i++) v[i] = b[src_bit(i)];
    return v;
  endfunction
endpackage

// File: rtl/tmr_wide_access.sv
module tmr_wide_access
  import tmr_bus_pkg::*;
#(
  parameter int NW = N_WIDE,
  parameter int BW = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BW-1:0]     acc_wdata,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [NW*2*BW-1:0] core_vals,
  output logic [2*BW-1:0]   commit_val,
  output logic [NW-1:0]     commit_load,
  output logic              wide_hit,
  output logic [BW-1:0]     rd_byte
);
  localparam int WW    = 2 * BW;
  localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1;

  logic [BW-1:0]    hold_q;
  logic [IDX_W-1:0] idx;
  logic             hi_sel;
  logic [WW-1:0]    sel_val;
  logic             lo_wr, hi_wr, lo_rd;

  assign wide_hit = acc_addr < ADDR_W'(2 * NW);
  assign idx      = acc_addr[IDX_W:1];
  assign hi_sel   = acc_addr[0];
  assign sel_val  = core_vals[idx*WW +: WW];
  assign lo_wr    = acc_wr && wide_hit && !hi_sel;
  assign hi_wr    = acc_wr && wide_hit &&  hi_sel;
  assign lo_rd    = acc_rd && wide_hit && !hi_sel;
  assign rd_byte  = hi_sel ? hold_q : sel_val[BW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= '0;
      commit_val  <= '0;
      commit_load <= '0;
    end else begin
      if (hi_wr)      hold_q <= acc_wdata;
      else if (lo_rd) hold_q <= sel_val[WW-1:BW];
      commit_load <= '0;
      if (lo_wr) begin
        commit_load[idx] <= 1'b1;
        commit_val       <= {hold_q, acc_wdata};
      end
    end
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_bus_pkg::*;
#(
  parameter int NS = N_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NS-1:0]     ev,
  input  logic [NS-1:0]     ack,
  input  logic              stat_wr,
  input  logic              ena_wr,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [NS-1:0]     stat_q,
  output logic [NS-1:0]     ena_q,
  output logic [NS-1:0]     req
);
  logic [NS-1:0] sw_clr;
  logic [NS-1:0] wr_bits;

  assign wr_bits = unpack_src(wbyte);
  assign sw_clr  = stat_wr ? wr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ena_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~(sw_clr | ack)) | ev;
      if (ena_wr) ena_q <= wr_bits;
    end
  end

  assign req = stat_q & ena_q;
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
  import tmr_bus_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [BYTE_W-1:0]          bus_wdata,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  output logic [BYTE_W-1:0]          bus_rdata,
  input  logic [N_WIDE*WORD_W-1:0]   wide_rd,
  output logic [WORD_W-1:0]          wide_wval,
  output logic [N_WIDE-1:0]          wide_load,
  input  logic                       ev_ovf,
  input  logic                       ev_cmpa,
  input  logic                       ev_cmpb,
  input  logic                       ev_cap,
  input  logic [N_SRC-1:0]           irq_ack,
  output logic [N_SRC-1:0]           irq_req,
  output logic                       irq_any
);
  logic [N_SRC-1:0]  ev_vec;
  logic [N_SRC-1:0]  flag_vec;
  logic [N_SRC-1:0]  mask_vec;
  logic              wide_hit;
  logic [BYTE_W-1:0] wide_byte;
  logic [BYTE_W-1:0] rd_next;

  assign ev_vec = {ev_cap, ev_cmpb, ev_cmpa, ev_ovf};

  tmr_wide_access u_wide (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_addr    (bus_addr),
    .acc_wdata   (bus_wdata),
    .acc_rd      (bus_rd),
    .acc_wr      (bus_wr),
    .core_vals   (wide_rd),
    .commit_val  (wide_wval),
    .commit_load (wide_load),
    .wide_hit    (wide_hit),
    .rd_byte     (wide_byte)
  );

  tmr_irq_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_vec),
    .ack     (irq_ack),
    .stat_wr (bus_wr && bus_addr == ADR_STAT),
    .ena_wr  (bus_wr && bus_addr == ADR_ENA),
    .wbyte   (bus_wdata),
    .stat_q  (flag_vec),
    .ena_q   (mask_vec),
    .req     (irq_req)
  );

  always_comb begin
    if (wide_hit)                   rd_next = wide_byte;
    else if (bus_addr == ADR_ENA)   rd_next = pack_src(mask_vec);
    else if (bus_addr == ADR_STAT)  rd_next = pack_src(flag_vec);
    else                            rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign irq_any = |irq_req;
endmodule

// File: rtl/tmr_bus_if_chk.sv
module tmr_bus_if_chk
  import tmr_bus_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              bus_wr,
  input logic [N_WIDE-1:0] wide_load,
  input logic [N_SRC-1:0]  ev_vec,
  input logic [N_SRC-1:0]  irq_ack,
  input logic [N_SRC-1:0]  flag_vec,
  input logic [N_SRC-1:0]  mask_vec,
  input logic [N_SRC-1:0]  irq_req
);
  logic lo_write;
  logic stat_write;
  assign lo_write   = bus_wr && (bus_addr < WIDE_SPAN) && !bus_addr[0];
  assign stat_write = bus_wr && (bus_addr == ADR_STAT);

  p_load_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wide_load));
  p_load_after_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_write |=> $countones(wide_load) == 1);
  p_no_load_else_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_write |=> wide_load == '0);

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    localparam int P = src_bit(k);
    p_event_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_vec[k] |=> flag_vec[k]);
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[k] && !ev_vec[k]) |=> !flag_vec[k]);
    p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_write && bus_wdata[P] && !ev_vec[k]) |=> !flag_vec[k]);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_vec[k] && !irq_ack[k] && !(stat_write && bus_wdata[P])) |=> $stable(flag_vec[k]));
    p_req_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[k] |-> (flag_vec[k] && mask_vec[k]));
  end
endmodule

bind tmr_bus_if tmr_bus_if_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .wide_load (wide_load),
  .ev_vec    (ev_vec),
  .irq_ack   (irq_ack),
  .flag_vec  (flag_vec),
  .mask_vec  (mask_vec),
  .irq_req   (irq_req)
);

// File: tb/sim_tmr_bus_if.sv
`timescale 1ns/1ps
module sim_tmr_bus_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic [63:0] wide_rd;
  logic [15:0] wide_wval;
  logic [3:0]  wide_load;
  logic        ev_ovf = 0, ev_cmpa = 0, ev_cmpb = 0, ev_cap = 0;
  logic [3:0]  irq_ack = '0;
  logic [3:0]  irq_req;
  logic        irq_any;

  logic [15:0] core [4];
  assign wide_rd = {core[3], core[2], core[1], core[0]};

  always #5 clk = ~clk;

  tmr_bus_if u0 (.*);

  // behavioural reference state
  logic [7:0]  m_hold = 0, m_rdata = 0;
  logic [3:0]  m_ena = 0, m_stat = 0, m_load = 0;
  logic [15:0] m_wval = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  function automatic logic [3:0] pick(input logic [7:0] b);
    return {b[5], b[2], b[1], b[0]};
  endfunction
  function automatic logic [7:0] place(input logic [3:0] v);
    return {2'b00, v[3], 2'b00, v[2], v[1], v[0]};
  endfunction

  task automatic model_edge();
    logic [7:0] nh, nr; logic [3:0] ns, ne, nl; logic [15:0] nw;
    logic [3:0] evs, clr; int a;
    a = bus_addr;
    nh = m_hold; nr = m_rdata; ne = m_ena; nl = 0; nw = m_wval;
    evs = {ev_cap, ev_cmpb, ev_cmpa, ev_ovf};
    clr = irq_ack;
    if (bus_wr && a == 9) clr = clr | pick(bus_wdata);
    ns = (m_stat & ~clr) | evs;
    if (bus_wr && a == 8) ne = pick(bus_wdata);
    if (bus_wr && a < 8 && a % 2 == 1) nh = bus_wdata;
    if (bus_wr && a < 8 && a % 2 == 0) begin
      nl = 4'(1 << (a / 2)); nw = {m_hold, bus_wdata};
    end
    if (bus_rd) begin
      if (a < 8 && a % 2 == 0) nr = core[a / 2][7:0];
      else if (a < 8) nr = m_hold;
      else if (a == 8) nr = place(m_ena);
      else if (a == 9) nr = place(m_stat);
      else nr = 0;
      if (a < 8 && a % 2 == 0 && !(bus_wr && a % 2 == 1)) nh = core[a / 2][15:8];
    end
    m_hold = nh; m_rdata = nr; m_stat = ns; m_ena = ne; m_load = nl; m_wval = nw;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rdata", bus_rdata, m_rdata);
    chk(tag, "load", wide_load, m_load);
    if (m_load != 0) chk(tag, "wval", wide_wval, m_wval);
    chk({tag, "/R11"}, "req", irq_req, m_stat & m_ena);
    chk({tag, "/R11"}, "any", irq_any, |(m_stat & m_ena));
  endtask

  // one bus cycle: inputs already set; sample after the edge, then idle them
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    bus_rd = 0; bus_wr = 0; irq_ack = 0;
    ev_ovf = 0; ev_cmpa = 0; ev_cmpb = 0; ev_cap = 0;
  endtask

  task automatic wr(input int a, input int d, input string tag);
    bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1; step(tag);
  endtask
  task automatic rd(input int a, input string tag);
    bus_addr = 4'(a); bus_rd = 1; step(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) core[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R12");
    rd(9, "R12"); rd(8, "R12"); rd(1, "R12");

    // R1 / R2: high byte held, low byte commits for each register
    for (int r = 0; r < 4; r++) begin
      wr(2 * r + 1, 8'hA0 + r, "R1");
      wr(2 * r, 8'h30 + r, "R2");
    end
    // R4: shared latch across registers
    wr(1, 8'h12, "R4");
    wr(6, 8'h34, "R4");
    // R3: atomic read with core change in between
    core[0] = 16'h5678; rd(0, "R3");
    core[0] = 16'h9A00; rd(1, "R3");
    core[3] = 16'hBEEF; rd(6, "R3"); rd(5, "R3");
    // R6: enable register masking and unused space
    wr(8, 8'hFF, "R6"); rd(8, "R6");
    rd(10, "R6"); rd(15, "R6");
    wr(8, 8'h00, "R6");
    // R7 / R5: events set status bits in the fixed layout
    ev_ovf = 1; step("R7"); ev_cap = 1; step("R7");
    ev_cmpa = 1; ev_cmpb = 1; step("R7");
    rd(9, "R5");
    // R11: partial enable
    wr(8, 8'h21, "R11"); step("R11");
    // R8: write one clears, zero keeps
    wr(9, 8'h00, "R8"); rd(9, "R8");
    wr(9, 8'h02, "R8"); rd(9, "R8");
    // R9: acknowledge clears
    irq_ack = 4'b1000; step("R9"); rd(9, "R9");
    // R10: set against software clear and against acknowledge
    ev_ovf = 1; bus_addr = 9; bus_wdata = 8'h01; bus_wr = 1; step("R10");
    rd(9, "R10");
    ev_cap = 1; irq_ack = 4'b1000; step("R10");
    rd(9, "R10");

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      int k;
      k = $urandom_range(0, 9);
      bus_addr = 4'($urandom_range(0, 15));
      bus_wdata = 8'($urandom);
      bus_wr = (k < 4); bus_rd = (k >= 3 && k < 7);
      {ev_cap, ev_cmpb, ev_cmpa, ev_ovf} = 4'($urandom) & 4'($urandom);
      irq_ack = 4'($urandom) & 4'($urandom);
      if (n % 7 == 0) core[$urandom_range(0, 3)] = 16'($urandom);
      step("R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule